// File: doc/BRIEF.md
# Multiplexed-Address DRAM Strobe Controller

This block connects a simple request/ready host port to a 64K x 4 dynamic RAM that has only eight address pins. Each host access carries a 16-bit address. The controller splits it into an 8-bit row half (address bits 7:0) and an 8-bit column half (bits 15:8). It sends both halves over the shared pins one after the other. Active-low row and column strobes latch each half into the device. The column strobe is also the device select, so no data moves unless it is low. Write data and the write strobe are set up before the column strobe falls. Read data is sampled in the last cycle of the column strobe and returned with a one-cycle valid pulse.

A free-running refresh timer raises a request once per row interval. The default interval is 976 cycles of a 125 MHz clock, which is a 2 ms sweep divided by 256 rows. The controller serves the request with a row-only cycle: an 8-bit refresh row counter goes onto the pins, the row strobe is pulsed, and the column strobe stays high. A pending refresh wins over a new host request, but it never cuts into a host access that has already started.

The sequencer has eight states:
- IDLE grants either REF_SETUP (refresh pending) or ROW_SETUP (host request accepted).
- A host access runs ROW_SETUP → ROW_HOLD → COL_SETUP → CAS_ACT → PRECHARGE → IDLE.
- A refresh runs REF_SETUP → REF_ACT → PRECHARGE → IDLE.
- Each state other than IDLE lasts a parameter number of cycles, counted down by one shared counter.

Top module: `dram_mux_ctrl`

## Requirements
- R1: After reset all four strobes (ras_n, cas_n, we_n, oe_n) are high, req_ready is high and rd_valid is low.
- R2: At the cycle the row strobe falls, the address pins carry the row half: bits 7:0 of the host address, or the refresh row. The pins keep that value for T_RAH cycles.
- R3: When the column strobe falls, the pins carry host address bits 15:8. They stay unchanged while the column strobe is low.
- R4: The column strobe is low only while the row strobe is low. It falls exactly T_RAH+T_RCD cycles after the row strobe and stays low for exactly T_CAS cycles.
- R5: Output enable and write enable are never low together. On a write, the data bus is driven and write enable is low at least one cycle before the column strobe falls.
- R6: A read returns the stored 4-bit value on rd_data with rd_valid high for exactly one cycle. That cycle comes T_ASU+T_RAH+T_RCD+T_CAS cycles after acceptance.
- R7: Every REFRESH_INTERVAL cycles, when no host access is in the way, a refresh cycle runs with the column strobe held high and the row strobe low for T_REF_RAS cycles. The refresh row starts at 0 and increments by one modulo 256.
- R8: A pending refresh is served before any new host request and never interrupts a host access. req_ready is low whenever the row strobe is low.
- R9: Between any two row-strobe pulses the row strobe stays high for at least T_RP+T_ASU cycles.
- R10: A request is accepted on a clock edge where req_valid and req_ready are both high. Each acceptance produces exactly one column-strobe access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Host word address |
| req_wdata | input | 4 | Host write data |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rd_valid | output | 1 | One-cycle pulse marking rd_data valid |
| rd_data | output | 4 | Read result |
| dram_addr | output | 8 | Shared row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe and device select, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 4 | Data driven to the memory |
| dram_dq_oe | output | 1 | Data bus drive enable |
| dram_dq_i | input | 4 | Data returned by the memory |

## Verification
The bench builds the controller with REFRESH_INTERVAL set to 64. At that setting a full 256-row refresh sweep, including the wrap back to row 0, finishes in a short run, and refreshes collide often with long streams of back-to-back host requests. The timing counts are set to unequal values: T_ASU=2, T_RAH=2, T_RCD=1, T_CAS=3, T_RP=2, T_REF_RAS=4. With distinct values, a phase that is shortened or swapped shows up as a wrong measured strobe distance or a wrong read latency.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_SETUP,
        ST_ROW_HOLD,
        ST_COL_SETUP,
        ST_CAS_ACT,
        ST_PRECHARGE,
        ST_REF_SETUP,
        ST_REF_ACT
    } seq_state_t;

    typedef enum logic [1:0] {
        PIN_ROW,
        PIN_COL,
        PIN_REF
    } pin_sel_t;

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 976,
    parameter int ROW_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_done,
    output logic             ref_pending,
    output logic [ROW_W-1:0] ref_row
);
    localparam int TW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    logic [TW-1:0] tick_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q      <= '0;
            ref_pending <= 1'b0;
            ref_row     <= '0;
        end else begin
            if (tick_q == LAST) begin
                tick_q      <= '0;
                ref_pending <= 1'b1;
            end else begin
                tick_q <= tick_q + TW'(1);
                if (ref_done) begin
                    ref_pending <= 1'b0;
                end
            end
            if (ref_done) begin
                ref_row <= ref_row + ROW_W'(1);
            end
        end
    end

endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W = 8
) (
    input  pin_sel_t         sel,
    input  logic [ROW_W-1:0] row_half,
    input  logic [ROW_W-1:0] col_half,
    input  logic [ROW_W-1:0] ref_row,
    output logic [ROW_W-1:0] pins
);
    always_comb begin
        unique case (sel)
            PIN_ROW: pins = row_half;
            PIN_COL: pins = col_half;
            PIN_REF: pins = ref_row;
            default: pins = row_half;
        endcase
    end

endmodule

// File: rtl/dram_seq_fsm.sv
module dram_seq_fsm
    import dram_ctrl_pkg::*;
#(
    parameter int T_ASU     = 1,
    parameter int T_RAH     = 1,
    parameter int T_RCD     = 1,
    parameter int T_CAS     = 2,
    parameter int T_RP      = 2,
    parameter int T_REF_RAS = 3
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     is_write,
    input  logic     ref_pending,
    output logic     ready,
    output logic     accept,
    output logic     ref_done,
    output logic     capture,
    output pin_sel_t pin_sel,
    output logic     ras_n,
    output logic     cas_n,
    output logic     we_n,
    output logic     oe_n,
    output logic     dq_oe
);
    localparam int M1   = (T_ASU > T_RAH) ? T_ASU : T_RAH;
    localparam int M2   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int M3   = (T_RP > T_REF_RAS) ? T_RP : T_REF_RAS;
    localparam int M12  = (M1 > M2) ? M1 : M2;
    localparam int TMAX = (M12 > M3) ? M12 : M3;
    localparam int CW   = $clog2(TMAX + 1);

    seq_state_t    state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic          last;

    function automatic logic [CW-1:0] dur(input seq_state_t s);
        unique case (s)
            ST_ROW_SETUP, ST_REF_SETUP: dur = CW'(T_ASU - 1);
            ST_ROW_HOLD:                dur = CW'(T_RAH - 1);
            ST_COL_SETUP:               dur = CW'(T_RCD - 1);
            ST_CAS_ACT:                 dur = CW'(T_CAS - 1);
            ST_PRECHARGE:               dur = CW'(T_RP - 1);
            ST_REF_ACT:                 dur = CW'(T_REF_RAS - 1);
            default:                    dur = '0;
        endcase
    endfunction

    assign last   = (cnt_q == '0);
    assign ready  = (state_q == ST_IDLE) && !ref_pending;
    assign accept = ready && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_pending)    state_d = ST_REF_SETUP;
                else if (req_valid) state_d = ST_ROW_SETUP;
            end
            ST_ROW_SETUP: if (last) state_d = ST_ROW_HOLD;
            ST_ROW_HOLD:  if (last) state_d = ST_COL_SETUP;
            ST_COL_SETUP: if (last) state_d = ST_CAS_ACT;
            ST_CAS_ACT:   if (last) state_d = ST_PRECHARGE;
            ST_PRECHARGE: if (last) state_d = ST_IDLE;
            ST_REF_SETUP: if (last) state_d = ST_REF_ACT;
            ST_REF_ACT:   if (last) state_d = ST_PRECHARGE;
            default:                state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d != state_q) begin
                cnt_q <= dur(state_d);
            end else if (!last) begin
                cnt_q <= cnt_q - CW'(1);
            end
        end
    end

    always_comb begin
        ras_n    = 1'b1;
        cas_n    = 1'b1;
        we_n     = 1'b1;
        oe_n     = 1'b1;
        dq_oe    = 1'b0;
        pin_sel  = PIN_ROW;
        ref_done = 1'b0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_ROW_SETUP, ST_PRECHARGE: begin
                pin_sel = PIN_ROW;
            end
            ST_ROW_HOLD: begin
                ras_n = 1'b0;
            end
            ST_COL_SETUP: begin
                ras_n   = 1'b0;
                pin_sel = PIN_COL;
                we_n    = !is_write;
                dq_oe   = is_write;
            end
            ST_CAS_ACT: begin
                ras_n   = 1'b0;
                cas_n   = 1'b0;
                pin_sel = PIN_COL;
                we_n    = !is_write;
                oe_n    = is_write;
                dq_oe   = is_write;
                capture = last && !is_write;
            end
            ST_REF_SETUP: begin
                pin_sel = PIN_REF;
            end
            ST_REF_ACT: begin
                ras_n    = 1'b0;
                pin_sel  = PIN_REF;
                ref_done = last;
            end
            default: begin
                pin_sel = PIN_ROW;
            end
        endcase
    end

endmodule

// File: rtl/dram_mux_ctrl.sv
module dram_mux_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W            = 8,
    parameter int DATA_W           = 4,
    parameter int T_ASU            = 1,
    parameter int T_RAH            = 1,
    parameter int T_RCD            = 1,
    parameter int T_CAS            = 2,
    parameter int T_RP             = 2,
    parameter int T_REF_RAS        = 3,
    parameter int REFRESH_INTERVAL = 976
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [2*ROW_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 req_ready,
    output logic                 rd_valid,
    output logic [DATA_W-1:0]    rd_data,
    output logic [ROW_W-1:0]     dram_addr,
    output logic                 dram_ras_n,
    output logic                 dram_cas_n,
    output logic                 dram_we_n,
    output logic                 dram_oe_n,
    output logic [DATA_W-1:0]    dram_dq_o,
    output logic                 dram_dq_oe,
    input  logic [DATA_W-1:0]    dram_dq_i
);
    localparam int ADDR_W = 2 * ROW_W;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              wr_q;
    logic              accept;
    logic              capture;
    logic              ref_pending;
    logic              ref_done;
    logic [ROW_W-1:0]  ref_row;
    pin_sel_t          pin_sel;

    dram_refresh_timer #(
        .INTERVAL (REFRESH_INTERVAL),
        .ROW_W    (ROW_W)
    ) refresh_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_done    (ref_done),
        .ref_pending (ref_pending),
        .ref_row     (ref_row)
    );

    dram_seq_fsm #(
        .T_ASU     (T_ASU),
        .T_RAH     (T_RAH),
        .T_RCD     (T_RCD),
        .T_CAS     (T_CAS),
        .T_RP      (T_RP),
        .T_REF_RAS (T_REF_RAS)
    ) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .is_write    (wr_q),
        .ref_pending (ref_pending),
        .ready       (req_ready),
        .accept      (accept),
        .ref_done    (ref_done),
        .capture     (capture),
        .pin_sel     (pin_sel),
        .ras_n       (dram_ras_n),
        .cas_n       (dram_cas_n),
        .we_n        (dram_we_n),
        .oe_n        (dram_oe_n),
        .dq_oe       (dram_dq_oe)
    );

    dram_addr_mux #(
        .ROW_W (ROW_W)
    ) mux_i (
        .sel      (pin_sel),
        .row_half (addr_q[ROW_W-1:0]),
        .col_half (addr_q[ADDR_W-1:ROW_W]),
        .ref_row  (ref_row),
        .pins     (dram_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            wr_q    <= 1'b0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            wr_q    <= req_write;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= capture;
            if (capture) begin
                rd_data <= dram_dq_i;
            end
        end
    end

    assign dram_dq_o = wdata_q;

endmodule

// File: rtl/dram_mux_ctrl_chk.sv
module dram_mux_ctrl_chk #(
    parameter int ROW_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             rd_valid,
    input logic [ROW_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             dram_oe_n,
    input logic             dram_dq_oe
);
    p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dram_oe_n && !dram_we_n));

    p_write_drives_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> dram_dq_oe);

    p_cas_inside_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    p_col_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_cas_n && !$past(dram_cas_n)) |-> $stable(dram_addr));

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_ras_n |-> !req_ready);

    p_rdv_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

bind dram_mux_ctrl dram_mux_ctrl_chk #(.ROW_W(ROW_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rd_valid   (rd_valid),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .dram_oe_n  (dram_oe_n),
    .dram_dq_oe (dram_dq_oe)
);

// File: tb/dram_mux_ctrl_tb_top.sv
module dram_mux_ctrl_tb_top;
    localparam int T_ASU     = 2;
    localparam int T_RAH     = 2;
    localparam int T_RCD     = 1;
    localparam int T_CAS     = 3;
    localparam int T_RP      = 2;
    localparam int T_REF_RAS = 4;
    localparam int INTERVAL  = 64;
    localparam int RD_LAT    = T_ASU + T_RAH + T_RCD + T_CAS;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic [7:0]  dram_addr;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n;
    logic [3:0]  dram_dq_o;
    logic        dram_dq_oe;
    logic [3:0]  dq_i_r = '0;

    dram_mux_ctrl #(
        .T_ASU(T_ASU), .T_RAH(T_RAH), .T_RCD(T_RCD), .T_CAS(T_CAS),
        .T_RP(T_RP), .T_REF_RAS(T_REF_RAS), .REFRESH_INTERVAL(INTERVAL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_oe_n(dram_oe_n), .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe),
        .dram_dq_i(dq_i_r)
    );

    int n_chk = 0;
    int n_bad = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // memory model and strobe monitor, sampled on falling edges
    logic [3:0] mem [logic [15:0]];
    int   cyc = 0;
    logic ras_p = 1'b1, cas_p = 1'b1, we_p = 1'b1;
    int   ras_fall_c = 0, ras_rise_c = 0, cas_fall_c = 0;
    bit   have_rise = 0, cas_in_ras = 0, wrap_seen = 0;
    logic [7:0] row_l = '0, col_l = '0, exp_ref_row = '0;
    int   ref_count = 0, host_count = 0, last_ref_fall = -1, last_ref_gap = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            ras_p = 1'b1; cas_p = 1'b1; we_p = 1'b1;
        end else begin
            cyc++;
            if (!dram_oe_n && !dram_we_n) chk(0, "R5 oe/we overlap", 0, 1);
            if (ras_p && !dram_ras_n) begin
                if (have_rise)
                    chk(cyc - ras_rise_c >= T_RP + T_ASU, "R9 precharge gap",
                        cyc - ras_rise_c, T_RP + T_ASU);
                chk(!req_ready, "R8 ready low during cycle", int'(req_ready), 0);
                row_l = dram_addr; ras_fall_c = cyc; cas_in_ras = 0;
            end
            if (!dram_ras_n && (cyc - ras_fall_c < T_RAH) && dram_addr != row_l)
                chk(0, "R2 row hold", int'(dram_addr), int'(row_l));
            if (cas_p && !dram_cas_n) begin
                chk(!dram_ras_n, "R4 cas outside ras", int'(dram_ras_n), 0);
                chk(cyc - ras_fall_c == T_RAH + T_RCD, "R4 ras-to-cas",
                    cyc - ras_fall_c, T_RAH + T_RCD);
                col_l = dram_addr; cas_fall_c = cyc; cas_in_ras = 1; host_count++;
                if (!dram_we_n) begin
                    chk(!we_p && dram_dq_oe, "R5 write setup", int'(we_p), 0);
                    mem[{dram_addr, row_l}] = dram_dq_o;
                end else begin
                    dq_i_r = mem.exists({dram_addr, row_l}) ? mem[{dram_addr, row_l}] : 4'h0;
                end
            end
            if (!cas_p && !dram_cas_n && dram_addr != col_l)
                chk(0, "R3 column moved", int'(dram_addr), int'(col_l));
            if (!cas_p && dram_cas_n) begin
                chk(cyc - cas_fall_c == T_CAS, "R4 cas width", cyc - cas_fall_c, T_CAS);
                dq_i_r = '0;
            end
            if (!ras_p && dram_ras_n) begin
                ras_rise_c = cyc; have_rise = 1;
                if (!cas_in_ras) begin
                    chk(row_l == exp_ref_row, "R7 refresh row", int'(row_l), int'(exp_ref_row));
                    chk(cyc - ras_fall_c == T_REF_RAS, "R7 refresh width",
                        cyc - ras_fall_c, T_REF_RAS);
                    if (last_ref_fall >= 0) last_ref_gap = ras_fall_c - last_ref_fall;
                    last_ref_fall = ras_fall_c;
                    if (row_l == 8'h00 && ref_count > 0) wrap_seen = 1;
                    exp_ref_row = exp_ref_row + 8'd1;
                    ref_count++;
                end
            end
            ras_p = dram_ras_n; cas_p = dram_cas_n; we_p = dram_we_n;
        end
    end

    task automatic issue(input bit wr, input logic [15:0] a, input logic [3:0] d);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_write(input logic [15:0] a, input logic [3:0] d);
        int h0;
        h0 = host_count;
        issue(1'b1, a, d);
        while (host_count == h0) @(negedge clk);
        chk(host_count == h0 + 1, "R10 one access per write", host_count - h0, 1);
        chk(row_l == a[7:0], "R2 write row half", int'(row_l), int'(a[7:0]));
        chk(col_l == a[15:8], "R3 write column half", int'(col_l), int'(a[15:8]));
    endtask

    task automatic do_read(input logic [15:0] a, input logic [3:0] exp);
        int h0, n;
        h0 = host_count;
        n  = 0;
        issue(1'b0, a, 4'h0);
        while (!rd_valid) begin @(negedge clk); n++; end
        chk(n == RD_LAT, "R6 read latency", n, RD_LAT);
        chk(rd_data == exp, "R6 read data", int'(rd_data), int'(exp));
        chk(host_count == h0 + 1, "R10 one access per read", host_count - h0, 1);
        chk(row_l == a[7:0], "R2 read row half", int'(row_l), int'(a[7:0]));
        chk(col_l == a[15:8], "R3 read column half", int'(col_l), int'(a[15:8]));
        @(negedge clk);
        chk(!rd_valid, "R6 valid single cycle", int'(rd_valid), 0);
    endtask

    task automatic t_reset;
        chk(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1 strobes idle",
            int'({dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}), 15);
        chk(req_ready, "R1 ready after reset", int'(req_ready), 1);
        chk(!rd_valid, "R1 no valid after reset", int'(rd_valid), 0);
    endtask

    task automatic t_patterns;
        logic [15:0] addrs [6];
        logic [3:0]  vals  [6];
        addrs = '{16'h0000, 16'hFFFF, 16'h12AB, 16'hAB12, 16'h00FF, 16'hFF00};
        vals  = '{4'h5, 4'hA, 4'h3, 4'hC, 4'h9, 4'h6};
        for (int i = 0; i < 6; i++) do_write(addrs[i], vals[i]);
        for (int i = 5; i >= 0; i--) do_read(addrs[i], vals[i]);
        do_write(16'h12AB, 4'hF);
        do_read(16'h12AB, 4'hF);
        do_read(16'hAB12, 4'hC);
    endtask

    task automatic t_interval;
        int r0;
        while (!req_ready) @(negedge clk);
        r0 = ref_count;
        while (ref_count < r0 + 2) @(negedge clk);
        chk(last_ref_gap == INTERVAL, "R7 refresh interval", last_ref_gap, INTERVAL);
    endtask

    task automatic t_priority;
        int r0, c0, span;
        r0 = ref_count; c0 = cyc;
        for (int i = 0; i < 40; i++) begin
            do_write(16'(i * 16'h0137), 4'(i));
            do_read(16'(i * 16'h0137), 4'(i));
        end
        span = cyc - c0;
        chk(ref_count - r0 >= span / INTERVAL - 1, "R8 refresh not starved",
            ref_count - r0, span / INTERVAL - 1);
    endtask

    task automatic t_wrap;
        while (ref_count < 258) @(negedge clk);
        chk(wrap_seen, "R7 refresh row wraps to 0", int'(wrap_seen), 1);
        do_read(16'hFFFF, 4'hA);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_patterns();
        t_interval();
        t_priority();
        t_wrap();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule